// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the 32-bit status and control word of one root port of a host controller. Software reaches it through a single-word bus: a write strobe with write data, and a read data word that always shows the current contents. The port hardware reports connect and over-current as levels. It also sends link-state updates, configuration-error pulses and cold-attach pulses. The block turns these inputs into status bits and into sticky change flags.

A status-change interrupt follows the change flags. Link-state writes from software take effect only when the link write strobe bit is set in the same write. A change flag for the link is raised on a fixed set of link-state transitions. A port reset is a hot reset (bit 4) or a warm reset (bit 31). Each is timed by a counter. When it ends, the port is in U0 and enabled, and the speed is loaded from `speed_in`.

The reset sequencer is a state machine with three states:
- IDLE goes to WARM when a warm reset is requested.
- IDLE goes to HOT when a hot reset is requested on a connected port.
- HOT and WARM return to IDLE when the count reaches `RESET_CYCLES`.

The link tracker holds the link state. Its codes are:

| Code | State | Code | State |
|------|-------|------|-------|
| 0 | U0 | 7 | Polling |
| 1 | U1 | 8 | Recovery |
| 2 | U2 | 9 | HotReset |
| 3 | U3 | 10 | Compliance |
| 4 | Disabled | 11 | Test |
| 5 | RxDetect | 15 | Resume |
| 6 | Inactive | | |

The link tracker remembers which state led into Recovery.

Top module: `root_port_csr`

## Requirements
- R1: Register layout:

  | Bit(s) | Field |
  |--------|-------|
  | 0 | connect |
  | 1 | enabled |
  | 3 | over-current |
  | 4 | port reset |
  | 8:5 | link state |
  | 9 | power |
  | 13:10 | speed |
  | 15:14 | indicator |
  | 16 | link write strobe, reads 0 |
  | 17 to 23 | change flags, in this order: connect, enable, warm reset, over-current, reset, link, configure error |
  | 24 | cold attach |
  | 27:25 | wake on connect, wake on disconnect, wake on over-current |
  | 30 | non-removable |
  | 31 | warm reset |

  Bits 2, 28 and 29 read 0. After reset the word reads 0x000002A0: power is 1, link is RxDetect (5), and every other bit is 0.
- R2: The `dev_present` and `oc_level` inputs appear in bit 0 and bit 3 one cycle later. Any change of `dev_present` sets the connect change flag (bit 17). Any change of `oc_level` sets the over-current change flag (bit 20).
- R3: Change flags are cleared by writing 1 to them. Writing 0 to a flag leaves it unchanged. A set event in the same cycle as a clear wins.
- R4: `irq` is 1 exactly while at least one change flag is 1.
- R5: A write changes the link state to the value in bits 8:5 only when bit 16 is 1 in that write. Codes 12 to 14 are ignored.
- R6: A `link_evt_valid` pulse with a valid code sets the link state. In the same cycle it takes priority over a software link write.
- R7: The link change flag (bit 22) is set on these transitions, and on no others:
  - U3 to Resume
  - Resume to U0
  - U3 to U0
  - U2 to U0
  - Recovery to U0, when Recovery was entered from U3 or from Resume
  - U0 to Disabled
  - any other state to Inactive
- R8: Writing 1 to bit 4 while connected starts a hot reset. During the hot reset, bit 4 reads 1 for `RESET_CYCLES` cycles and the link reads HotReset (9). When it ends:
  - bit 4 clears
  - the reset change flag (bit 21) is set
  - the port is enabled
  - the link is U0
  - the speed is loaded from `speed_in`

  A hot reset request while disconnected is ignored.
- R9: Writing 1 to bit 31 starts a warm reset. During the warm reset, bits 31 and 4 read 1 for `RESET_CYCLES` cycles and the link reads Polling (7). When it ends:
  - the warm reset change flag (bit 19) is set
  - the reset change flag (bit 21) is set
  - cold attach clears
  - the port ends as for a hot reset

  If one write requests both resets, the warm reset is chosen.
- R10: A disconnect or a rising over-current clears the enable bit and sets the enable change flag (bit 18). A disconnect also zeroes the speed. Writing 1 to bit 1 clears the enable bit without setting the enable change flag.
- R11: A `cfg_err` pulse sets the configure error flag (bit 23). A `cold_attach` pulse sets bit 24.
- R12: Power, indicator and wake enables read back as written. Bit 30 shows `dev_fixed`.
- R13: While a reset is running, link events and strobed link writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Current register contents |
| irq | output | 1 | Status-change interrupt |
| dev_present | input | 1 | Device connect level from the port |
| oc_level | input | 1 | Over-current level from the port |
| link_evt_valid | input | 1 | Link-state update from the port |
| link_evt_code | input | 4 | New link-state code |
| cfg_err | input | 1 | Link partner configuration failure pulse |
| cold_attach | input | 1 | Cold attach detection pulse |
| dev_fixed | input | 1 | Device is non-removable |
| speed_in | input | 4 | Negotiated speed code, loaded when a reset ends |

## Verification
A wrong internal state shows up at the ports within one or two cycles, through the read word and `irq`. A lost change flag leaves bit 17 to 23 and `irq` low one cycle after the event. A wrong sequencer state shows in bits 4 and 31. A count that is off by one moves the reset completion by a cycle, and the cycle-exact sampling catches that shift. A stale Recovery predecessor shows as a wrong link change flag one cycle after Recovery ends. The bench sweeps every pair of valid link codes through RxDetect and compares the link flag with a transition table computed in the bench.

// File: rtl/rpsc_pkg.sv
package rpsc_pkg;

    typedef enum logic [3:0] {
        LS_U0         = 4'd0,
        LS_U1         = 4'd1,
        LS_U2         = 4'd2,
        LS_U3         = 4'd3,
        LS_DISABLED   = 4'd4,
        LS_RXDETECT   = 4'd5,
        LS_INACTIVE   = 4'd6,
        LS_POLLING    = 4'd7,
        LS_RECOVERY   = 4'd8,
        LS_HOTRESET   = 4'd9,
        LS_COMPLIANCE = 4'd10,
        LS_TEST       = 4'd11,
        LS_RESUME     = 4'd15
    } link_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HOT  = 2'd1,
        RS_WARM = 2'd2
    } rst_state_e;

    localparam int unsigned NUM_CHG = 7;

    // change flag indexes, flag k lives at register bit CHG_LSB + k
    localparam int unsigned CHG_CONN = 0;
    localparam int unsigned CHG_EN   = 1;
    localparam int unsigned CHG_WARM = 2;
    localparam int unsigned CHG_OVC  = 3;
    localparam int unsigned CHG_RST  = 4;
    localparam int unsigned CHG_LINK = 5;
    localparam int unsigned CHG_CFG  = 6;

    localparam int unsigned B_CONN   = 0;
    localparam int unsigned B_EN     = 1;
    localparam int unsigned B_OVC    = 3;
    localparam int unsigned B_RST    = 4;
    localparam int unsigned B_LNK_LO = 5;
    localparam int unsigned B_LNK_HI = 8;
    localparam int unsigned B_PWR    = 9;
    localparam int unsigned B_SPD_LO = 10;
    localparam int unsigned B_SPD_HI = 13;
    localparam int unsigned B_IND_LO = 14;
    localparam int unsigned B_IND_HI = 15;
    localparam int unsigned B_LSTRB  = 16;
    localparam int unsigned CHG_LSB  = 17;
    localparam int unsigned CHG_MSB  = CHG_LSB + NUM_CHG - 1;
    localparam int unsigned B_CAS    = 24;
    localparam int unsigned B_WK_LO  = 25;
    localparam int unsigned B_WK_HI  = 27;
    localparam int unsigned B_FIXED  = 30;
    localparam int unsigned B_WARM   = 31;

    function automatic logic link_code_ok(input logic [3:0] code);
        return (code <= 4'd11) || (code == 4'd15);
    endfunction

endpackage

// File: rtl/rpsc_chg_flags.sv
module rpsc_chg_flags #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    flags[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    flags[i] <= 1'b0;
                end
            end

            // R3: set event wins over a clear in the same cycle
            assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> flags[i]);

            // R3: write-one-to-clear drops the flag when no event arrives
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
        end
    endgenerate

endmodule

// File: rtl/rpsc_reset_seq.sv
module rpsc_reset_seq
    import rpsc_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_hot,
    input  logic start_warm,
    output logic busy,
    output logic warm_busy,
    output logic done,
    output logic done_warm
);

    localparam int unsigned CW = (RESET_CYCLES < 2) ? 1 : $clog2(RESET_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (start_warm) begin
                    state_d = RS_WARM;
                end else if (start_hot) begin
                    state_d = RS_HOT;
                end
            end
            RS_HOT, RS_WARM: begin
                if (last) begin
                    state_d = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RS_IDLE || last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    always_comb begin
        busy      = 1'b0;
        warm_busy = 1'b0;
        done      = 1'b0;
        done_warm = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HOT: begin
                busy = 1'b1;
                done = last;
            end
            RS_WARM: begin
                busy      = 1'b1;
                warm_busy = 1'b1;
                done      = last;
                done_warm = last;
            end
            default: ;
        endcase
    end

    // R8: the counter never passes the programmed duration
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < CW'(RESET_CYCLES)));

    // R8: completion always returns the sequencer to idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == RS_IDLE));

    // R9: a warm request from idle always takes the warm path
    assert_warm_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && start_warm) |=> warm_busy);

endmodule

// File: rtl/rpsc_link_fsm.sv
module rpsc_link_fsm
    import rpsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       go_hot,
    input  logic       go_warm,
    input  logic       rst_done,
    input  logic       hw_valid,
    input  logic [3:0] hw_code,
    input  logic       sw_valid,
    input  logic [3:0] sw_code,
    output link_e      link,
    output logic       plc_evt
);

    link_e cur_q, nxt, pre_q;

    always_comb begin
        nxt = cur_q;
        if (rst_done) begin
            nxt = LS_U0;
        end else if (go_warm) begin
            nxt = LS_POLLING;
        end else if (go_hot) begin
            nxt = LS_HOTRESET;
        end else if (hold) begin
            nxt = cur_q;
        end else if (hw_valid && link_code_ok(hw_code)) begin
            nxt = link_e'(hw_code);
        end else if (sw_valid && link_code_ok(sw_code)) begin
            nxt = link_e'(sw_code);
        end
    end

    always_comb begin
        plc_evt = 1'b0;
        if (nxt != cur_q) begin
            if (nxt == LS_INACTIVE) begin
                plc_evt = 1'b1;
            end else begin
                unique case (cur_q)
                    LS_U3:       plc_evt = (nxt == LS_RESUME) || (nxt == LS_U0);
                    LS_RESUME:   plc_evt = (nxt == LS_U0);
                    LS_U2:       plc_evt = (nxt == LS_U0);
                    LS_U0:       plc_evt = (nxt == LS_DISABLED);
                    LS_RECOVERY: plc_evt = (nxt == LS_U0) &&
                                           ((pre_q == LS_U3) || (pre_q == LS_RESUME));
                    default:     plc_evt = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LS_RXDETECT;
            pre_q <= LS_RXDETECT;
        end else begin
            cur_q <= nxt;
            if (nxt == LS_RECOVERY && cur_q != LS_RECOVERY) begin
                pre_q <= cur_q;
            end
        end
    end

    assign link = cur_q;

    // R13: a running reset freezes the link state
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !rst_done) |=> (link == $past(link)));

    // R8: completion of a reset lands in U0
    assert_done_u0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> (link == LS_U0));

endmodule

// File: rtl/root_port_csr.sv
module root_port_csr
    import rpsc_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = 64,
    parameter bit          POWER_AT_RESET = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    input  logic        dev_present,
    input  logic        oc_level,
    input  logic        link_evt_valid,
    input  logic [3:0]  link_evt_code,
    input  logic        cfg_err,
    input  logic        cold_attach,
    input  logic        dev_fixed,
    input  logic [3:0]  speed_in
);

    localparam int unsigned WK_W  = B_WK_HI - B_WK_LO + 1;
    localparam int unsigned IND_W = B_IND_HI - B_IND_LO + 1;
    localparam int unsigned SPD_W = B_SPD_HI - B_SPD_LO + 1;

    logic               conn_q, ovc_q, en_q, pwr_q, cas_q;
    logic [SPD_W-1:0]   spd_q;
    logic [IND_W-1:0]   ind_q;
    logic [WK_W-1:0]    wake_q;
    logic [NUM_CHG-1:0] chg_set, chg_clr, chg_q;

    logic  rst_busy, rst_warm_busy, rst_done, rst_done_warm;
    logic  req_hot, req_warm, go_hot, go_warm;
    logic  conn_fall, ovc_rise, plc_evt;
    link_e link;

    // request decode, reset writes accepted only from idle
    assign req_warm = wr_en && wdata[B_WARM];
    assign req_hot  = wr_en && wdata[B_RST] && conn_q;
    assign go_warm  = req_warm && !rst_busy;
    assign go_hot   = req_hot && !req_warm && !rst_busy;

    assign conn_fall = conn_q && !dev_present;
    assign ovc_rise  = !ovc_q && oc_level;

    rpsc_reset_seq #(
        .RESET_CYCLES (RESET_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hot  (go_hot),
        .start_warm (go_warm),
        .busy       (rst_busy),
        .warm_busy  (rst_warm_busy),
        .done       (rst_done),
        .done_warm  (rst_done_warm)
    );

    rpsc_link_fsm u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (rst_busy),
        .go_hot   (go_hot),
        .go_warm  (go_warm),
        .rst_done (rst_done),
        .hw_valid (link_evt_valid),
        .hw_code  (link_evt_code),
        .sw_valid (wr_en && wdata[B_LSTRB]),
        .sw_code  (wdata[B_LNK_HI:B_LNK_LO]),
        .link     (link),
        .plc_evt  (plc_evt)
    );

    always_comb begin
        chg_set           = '0;
        chg_set[CHG_CONN] = conn_q ^ dev_present;
        chg_set[CHG_EN]   = en_q && (conn_fall || ovc_rise) && !rst_done;
        chg_set[CHG_WARM] = rst_done_warm;
        chg_set[CHG_OVC]  = ovc_q ^ oc_level;
        chg_set[CHG_RST]  = rst_done;
        chg_set[CHG_LINK] = plc_evt;
        chg_set[CHG_CFG]  = cfg_err;
        chg_clr           = wr_en ? wdata[CHG_MSB:CHG_LSB] : '0;
    end

    rpsc_chg_flags #(
        .N (NUM_CHG)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (chg_set),
        .clr_vec (chg_clr),
        .flags   (chg_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            ovc_q  <= 1'b0;
            en_q   <= 1'b0;
            spd_q  <= '0;
            cas_q  <= 1'b0;
            pwr_q  <= POWER_AT_RESET;
            ind_q  <= '0;
            wake_q <= '0;
        end else begin
            conn_q <= dev_present;
            ovc_q  <= oc_level;

            if (rst_done) begin
                en_q  <= dev_present && !oc_level;
                spd_q <= dev_present ? speed_in : '0;
            end else begin
                if (conn_fall || ovc_rise || (wr_en && wdata[B_EN])) begin
                    en_q <= 1'b0;
                end
                if (conn_fall) begin
                    spd_q <= '0;
                end
            end

            if (cold_attach) begin
                cas_q <= 1'b1;
            end else if (rst_done_warm) begin
                cas_q <= 1'b0;
            end

            if (wr_en) begin
                pwr_q  <= wdata[B_PWR];
                ind_q  <= wdata[B_IND_HI:B_IND_LO];
                wake_q <= wdata[B_WK_HI:B_WK_LO];
            end
        end
    end

    always_comb begin
        rdata                   = '0;
        rdata[B_CONN]           = conn_q;
        rdata[B_EN]             = en_q;
        rdata[B_OVC]            = ovc_q;
        rdata[B_RST]            = rst_busy;
        rdata[B_LNK_HI:B_LNK_LO] = link;
        rdata[B_PWR]            = pwr_q;
        rdata[B_SPD_HI:B_SPD_LO] = spd_q;
        rdata[B_IND_HI:B_IND_LO] = ind_q;
        rdata[CHG_MSB:CHG_LSB]  = chg_q;
        rdata[B_CAS]            = cas_q;
        rdata[B_WK_HI:B_WK_LO]  = wake_q;
        rdata[B_FIXED]          = dev_fixed;
        rdata[B_WARM]           = rst_warm_busy;
    end

    assign irq = |chg_q;

    // R4: any flag-setting event raises the interrupt next cycle
    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_set) |=> irq);

    // R5: a write without the strobe never moves the link
    assert_strobe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[B_LSTRB] && !link_evt_valid && !rst_busy && !go_hot && !go_warm)
        |=> (link == $past(link)));

    // R7: entry into Inactive always leaves the link change flag set
    assert_inactive_plc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link == LS_INACTIVE && $past(link) != LS_INACTIVE) |-> chg_q[CHG_LINK]);

    // R9: while a warm reset runs the port reset bit also reads 1
    assert_warm_has_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[B_WARM] |-> rdata[B_RST]);

endmodule

// File: tb/sim_root_port_csr.sv
module sim_root_port_csr;

    localparam int RST_N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        dev_present = 1'b0;
    logic        oc_level = 1'b0;
    logic        evt_v = 1'b0;
    logic [3:0]  evt_c = '0;
    logic        cfg_err = 1'b0;
    logic        cold = 1'b0;
    logic        dev_fixed = 1'b0;
    logic [3:0]  speed_in = 4'd3;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] keep = 32'h0000_0200;

    always #5 clk = ~clk;

    root_port_csr #(.RESET_CYCLES(RST_N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .irq(irq), .dev_present(dev_present), .oc_level(oc_level),
        .link_evt_valid(evt_v), .link_evt_code(evt_c), .cfg_err(cfg_err),
        .cold_attach(cold), .dev_fixed(dev_fixed), .speed_in(speed_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1;
        wdata = v | keep;
        step();
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic clr_all();
        wr(32'h00FE_0000);
    endtask

    task automatic hw_link(input logic [3:0] c);
        evt_v = 1'b1;
        evt_c = c;
        step();
        evt_v = 1'b0;
    endtask

    task automatic hot_reset();
        wr(32'h0000_0010);
        repeat (RST_N) step();
    endtask

    function automatic logic [31:0] fld(input int lo, input int w);
        return (rdata >> lo) & ((32'd1 << w) - 1);
    endfunction

    function automatic logic exp_plc(input int pre, input int f, input int t);
        if (f == t) return 1'b0;
        if (t == 6) return 1'b1;
        if (f == 3 && (t == 15 || t == 0)) return 1'b1;
        if (f == 15 && t == 0) return 1'b1;
        if (f == 2 && t == 0) return 1'b1;
        if (f == 0 && t == 4) return 1'b1;
        if (f == 8 && t == 0 && (pre == 3 || pre == 15)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset value", rdata, 32'h0000_02A0);
        chk("R4 irq after reset", {31'd0, irq}, 32'd0);

        // connect and flag clear rules
        dev_present = 1'b1;
        step();
        chk("R2 connect bit", fld(0, 1), 1);
        chk("R2 connect change", fld(17, 1), 1);
        chk("R4 irq set", {31'd0, irq}, 1);
        wr(32'h0);
        chk("R3 write 0 keeps flag", fld(17, 1), 1);
        wr(32'h0002_0000);
        chk("R3 w1c clears", fld(17, 1), 0);
        chk("R4 irq clear", {31'd0, irq}, 0);
        dev_present = 1'b0;
        step();
        dev_present = 1'b1;
        wr(32'h0002_0000);
        chk("R3 set beats clear", fld(17, 1), 1);
        clr_all();

        // hot reset
        speed_in = 4'd3;
        wr(32'h0000_0010);
        chk("R8 reset bit on", fld(4, 1), 1);
        chk("R8 link HotReset", fld(5, 4), 9);
        hw_link(4'd3);
        chk("R13 link held in reset", fld(5, 4), 9);
        for (int k = 2; k < RST_N; k++) begin
            step();
            chk("R8 reset bit held", fld(4, 1), 1);
        end
        step();
        chk("R8 reset bit done", fld(4, 1), 0);
        chk("R8 reset change", fld(21, 1), 1);
        chk("R8 enabled", fld(1, 1), 1);
        chk("R8 link U0", fld(5, 4), 0);
        chk("R8 speed loaded", fld(10, 4), 3);
        chk("R7 no flag after reset", fld(22, 1), 0);
        clr_all();

        // strobe gating
        wr(32'h0000_0060);
        chk("R5 no strobe ignored", fld(5, 4), 0);
        wr(32'h0001_0060);
        chk("R5 strobed write", fld(5, 4), 3);
        chk("R1 strobe reads 0", fld(16, 1), 0);
        wr(32'h0001_0180);
        chk("R5 reserved code ignored", fld(5, 4), 3);
        evt_v = 1'b1;
        evt_c = 4'd2;
        wr(32'h0001_0020);
        evt_v = 1'b0;
        chk("R6 hw beats sw", fld(5, 4), 2);

        // recovery paths
        hw_link(4'd3);
        clr_all();
        hw_link(4'd8);
        chk("R7 U3 to Recovery no flag", fld(22, 1), 0);
        hw_link(4'd0);
        chk("R7 U3 via Recovery to U0", fld(22, 1), 1);
        clr_all();
        hw_link(4'd15);
        clr_all();
        hw_link(4'd8);
        hw_link(4'd0);
        chk("R7 Resume via Recovery to U0", fld(22, 1), 1);
        clr_all();

        // sweep over every valid pair
        for (int f = 0; f < 16; f++) begin
            if (f >= 12 && f <= 14) continue;
            for (int t = 0; t < 16; t++) begin
                if (t >= 12 && t <= 14) continue;
                hw_link(4'd5);
                hw_link(4'(f));
                clr_all();
                hw_link(4'(t));
                chk($sformatf("R7 sweep %0d to %0d", f, t), fld(22, 1),
                    {31'd0, exp_plc(5, f, t)});
            end
        end
        clr_all();

        // enable bit rules
        hot_reset();
        clr_all();
        wr(32'h0000_0002);
        chk("R10 sw disable", fld(1, 1), 0);
        chk("R10 sw disable no change flag", fld(18, 1), 0);
        hot_reset();
        clr_all();
        oc_level = 1'b1;
        step();
        chk("R2 over-current bit", fld(3, 1), 1);
        chk("R2 over-current change", fld(20, 1), 1);
        chk("R10 oc disables", fld(1, 1), 0);
        chk("R10 oc enable change", fld(18, 1), 1);
        oc_level = 1'b0;
        step();
        clr_all();
        hot_reset();
        clr_all();
        dev_present = 1'b0;
        step();
        chk("R2 disconnect change", fld(17, 1), 1);
        chk("R10 disconnect disables", fld(1, 1), 0);
        chk("R10 disconnect enable change", fld(18, 1), 1);
        chk("R10 speed zeroed", fld(10, 4), 0);
        clr_all();
        wr(32'h0000_0010);
        chk("R8 hot reset ignored when disconnected", fld(4, 1), 0);

        // warm reset
        dev_present = 1'b1;
        speed_in = 4'd4;
        step();
        clr_all();
        cold = 1'b1;
        step();
        cold = 1'b0;
        chk("R11 cold attach", fld(24, 1), 1);
        cfg_err = 1'b1;
        step();
        cfg_err = 1'b0;
        chk("R11 config error flag", fld(23, 1), 1);
        clr_all();
        wr(32'h8000_0000);
        chk("R9 warm bit", fld(31, 1), 1);
        chk("R9 reset bit in warm", fld(4, 1), 1);
        chk("R9 link Polling", fld(5, 4), 7);
        repeat (RST_N - 1) step();
        chk("R9 warm held", fld(31, 1), 1);
        step();
        chk("R9 warm done", fld(31, 1), 0);
        chk("R9 warm change", fld(19, 1), 1);
        chk("R9 reset change", fld(21, 1), 1);
        chk("R9 cold attach cleared", fld(24, 1), 0);
        chk("R9 link U0", fld(5, 4), 0);
        chk("R9 enabled speed", fld(10, 4), 4);
        clr_all();
        wr(32'h8000_0010);
        chk("R9 warm chosen over hot", fld(31, 1), 1);
        repeat (RST_N) step();
        chk("R9 warm change both", fld(19, 1), 1);
        clr_all();

        // read/write fields
        keep = 32'h3E00_C204;
        wr(32'h0);
        chk("R12 rw fields", rdata & 32'h3E00_C204, 32'h0E00_C200);
        dev_fixed = 1'b1;
        step();
        chk("R12 non-removable", fld(30, 1), 1);
        keep = 32'h0;
        wr(32'h0);
        chk("R12 power off", fld(9, 1), 0);
        chk("R12 indicator off", fld(14, 2), 0);
        chk("R4 irq idle", {31'd0, irq}, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule